// File: doc/BRIEF.md
# Counter-Mode Keystream and Tag Sequencer

This block runs the counter-mode side of an authenticated-encryption session around a block cipher that sits outside it. A session begins with a start pulse that carries a 96-bit IV and the direction. The block builds the initial counter block from the IV and has it encrypted first. It keeps that result for the end of the session. It then takes 128-bit data blocks one at a time. For each block it issues the next counter value to the cipher, XORs the returned keystream with the data and presents the result. The last block may be partial: a byte count says how much of it is valid, and the unused tail of the output is zeroed.

After the last block, the block waits for the hash result from an external hash engine. The tag is the hash XORed with the saved encryption of the initial counter, truncated to its most significant bits. In decrypt mode the block also compares this tag with a supplied reference tag and reports pass or fail. The cipher port uses a valid/ready request and an in-order response, and only one request is in flight at a time.

Top module: `ctr_tag_unit`

## Requirements
- R1: While reset is high and in the cycle after it, `req_valid`, `din_ready`, `dout_valid`, `tag_valid`, `auth_pass` and `auth_fail` are all low.
- R2: The first cipher request of a session is the IV in the upper 96 bits, followed by 31 zero bits and a final 1 bit in bit 0.
- R3: For each data block the block issues exactly one further request. Its upper 96 bits equal those of the previous request, and its low 32 bits are the previous low 32 bits plus one, modulo 2^32.
- R4: For a full block, `dout_data` equals `din_data` XOR the keystream returned for that block's counter, in both encrypt and decrypt mode.
- R5: When `din_last` is set, `din_bytes` (7 bits) gives the number of valid bytes. A value k from 1 to 15 keeps the top 8k bits of the XOR result and drives the rest to zero; 0 or any value of 16 or more means a full block. `dout_last` and `dout_bytes` repeat the flag and the count of the block that produced the output.
- R6: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_block` does not change.
- R7: A `hash_valid` pulse after the last output block produces a one-cycle `tag_valid` with `tag_out` equal to the top TAG_W bits of (`hash_in` XOR the cipher output for the initial counter).
- R8: In decrypt mode, `auth_pass` is raised with `tag_valid` when `tag_out` equals `tag_ref`, and `auth_fail` is raised when it does not. In encrypt mode neither is raised, and the two are never high together.
- R9: `din_ready` is high only within a session. Data offered while no session runs is not consumed and yields no output, and a start pulse during a session is ignored.
- R10: No new cipher request is raised while an accepted request still awaits its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a session when idle |
| decrypt | input | 1 | Direction for the session, sampled with start |
| iv | input | IV_W | IV sampled with start |
| din_valid | input | 1 | Input block offered |
| din_ready | output | 1 | Input block accepted this cycle when valid |
| din_data | input | BLK_W | Input block, first byte in the top bits |
| din_last | input | 1 | Marks the final data block |
| din_bytes | input | 7 | Valid byte count of the final block |
| dout_valid | output | 1 | Output block present (one cycle) |
| dout_data | output | BLK_W | Output block |
| dout_last | output | 1 | Output is the final block |
| dout_bytes | output | 7 | Byte count carried from the input |
| req_valid | output | 1 | Counter block offered to the cipher |
| req_ready | input | 1 | Cipher accepts the request |
| req_block | output | BLK_W | Counter block to encrypt |
| rsp_valid | input | 1 | Cipher result present |
| rsp_block | input | BLK_W | Cipher result |
| hash_valid | input | 1 | Hash result present |
| hash_in | input | BLK_W | Hash result |
| tag_ref | input | TAG_W | Reference tag for decrypt |
| tag_valid | output | 1 | Tag present (one cycle) |
| tag_out | output | TAG_W | Truncated tag |
| auth_pass | output | 1 | Decrypt tag matched |
| auth_fail | output | 1 | Decrypt tag mismatched |

## Verification
Sessions run with an all-zero IV and several patterned IVs, with one to three blocks each, so that counter sequences are told apart from a stuck or wrongly placed increment. The final block lengths span one byte, fifteen bytes, a full block given as sixteen, and a full block given as zero, which separates the masking boundary from an off-by-one byte. Decrypt sessions with a matching and a flipped reference tag separate pass from fail and check the truncation to a 96-bit tag. Cipher handshakes with stalled ready and varying response delay show that requests stay stable and are never overlapped.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  localparam int BYTES_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ0  = 3'd1,
    ST_WAIT0 = 3'd2,
    ST_DATA  = 3'd3,
    ST_REQ   = 3'd4,
    ST_RSP   = 3'd5,
    ST_FIN   = 3'd6
  } seq_state_t;
endpackage

// File: rtl/ctr_gen.sv
module ctr_gen #(
  parameter int BLK_W = 128,
  parameter int IV_W  = 96,
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IV_W-1:0]  iv,
  input  logic             inc,
  output logic [BLK_W-1:0] ctr
);
  localparam int PAD_W = BLK_W - IV_W;
  localparam int HI_W  = BLK_W - CTR_W;

  logic [CTR_W-1:0] low_next;

  assign low_next = ctr[CTR_W-1:0] + CTR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr <= '0;
    end else if (load) begin
      ctr <= {iv, {(PAD_W-1){1'b0}}, 1'b1};
    end else if (inc) begin
      ctr <= {ctr[BLK_W-1 -: HI_W], low_next};
    end
  end
endmodule

// File: rtl/ks_mask.sv
module ks_mask #(
  parameter int BLK_W   = 128,
  parameter int BYTES_W = 7
) (
  input  logic [BLK_W-1:0]   data,
  input  logic [BLK_W-1:0]   ks,
  input  logic               last,
  input  logic [BYTES_W-1:0] bytes,
  output logic [BLK_W-1:0]   result
);
  localparam int NB = BLK_W / 8;

  logic [BLK_W-1:0] keep;
  int               drop_bits;

  always_comb begin
    drop_bits = 0;
    if (last && bytes != '0 && int'(bytes) < NB) begin
      drop_bits = (NB - int'(bytes)) * 8;
    end
    keep   = {BLK_W{1'b1}} << drop_bits;
    result = (data ^ ks) & keep;
  end
endmodule

// File: rtl/tag_unit.sv
module tag_unit #(
  parameter int BLK_W = 128,
  parameter int TAG_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             dec,
  input  logic [BLK_W-1:0] hash,
  input  logic [BLK_W-1:0] ek0,
  input  logic [TAG_W-1:0] ref_tag,
  output logic             tag_valid,
  output logic [TAG_W-1:0] tag_out,
  output logic             pass,
  output logic             fail
);
  logic [BLK_W-1:0] full_tag;
  logic [TAG_W-1:0] short_tag;

  assign full_tag  = hash ^ ek0;
  assign short_tag = full_tag[BLK_W-1 -: TAG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_valid <= 1'b0;
      tag_out   <= '0;
      pass      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      tag_valid <= fire;
      pass      <= fire && dec && (short_tag == ref_tag);
      fail      <= fire && dec && (short_tag != ref_tag);
      if (fire) tag_out <= short_tag;
    end
  end
endmodule

// File: rtl/ctr_tag_unit.sv
module ctr_tag_unit
  import ctr_pkg::*;
#(
  parameter int BLK_W = 128,
  parameter int IV_W  = 96,
  parameter int CTR_W = 32,
  parameter int TAG_W = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               decrypt,
  input  logic [IV_W-1:0]    iv,
  input  logic               din_valid,
  output logic               din_ready,
  input  logic [BLK_W-1:0]   din_data,
  input  logic               din_last,
  input  logic [BYTES_W-1:0] din_bytes,
  output logic               dout_valid,
  output logic [BLK_W-1:0]   dout_data,
  output logic               dout_last,
  output logic [BYTES_W-1:0] dout_bytes,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [BLK_W-1:0]   req_block,
  input  logic               rsp_valid,
  input  logic [BLK_W-1:0]   rsp_block,
  input  logic               hash_valid,
  input  logic [BLK_W-1:0]   hash_in,
  input  logic [TAG_W-1:0]   tag_ref,
  output logic               tag_valid,
  output logic [TAG_W-1:0]   tag_out,
  output logic               auth_pass,
  output logic               auth_fail
);
  seq_state_t         state;
  logic               dec_q;
  logic [BLK_W-1:0]   ek0_q;
  logic [BLK_W-1:0]   data_q;
  logic               last_q;
  logic [BYTES_W-1:0] bytes_q;
  logic [BLK_W-1:0]   masked;

  logic load_ctr, inc_ctr, take_din, tag_fire;

  assign load_ctr  = (state == ST_IDLE) && start;
  assign take_din  = (state == ST_DATA) && din_valid;
  assign inc_ctr   = take_din;
  assign tag_fire  = (state == ST_FIN) && hash_valid;
  assign din_ready = (state == ST_DATA);
  assign req_valid = (state == ST_REQ0) || (state == ST_REQ);

  ctr_gen #(.BLK_W(BLK_W), .IV_W(IV_W), .CTR_W(CTR_W)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .load (load_ctr),
    .iv   (iv),
    .inc  (inc_ctr),
    .ctr  (req_block)
  );

  ks_mask #(.BLK_W(BLK_W), .BYTES_W(BYTES_W)) u_mask (
    .data   (data_q),
    .ks     (rsp_block),
    .last   (last_q),
    .bytes  (bytes_q),
    .result (masked)
  );

  tag_unit #(.BLK_W(BLK_W), .TAG_W(TAG_W)) u_tag (
    .clk       (clk),
    .rst       (rst),
    .fire      (tag_fire),
    .dec       (dec_q),
    .hash      (hash_in),
    .ek0       (ek0_q),
    .ref_tag   (tag_ref),
    .tag_valid (tag_valid),
    .tag_out   (tag_out),
    .pass      (auth_pass),
    .fail      (auth_fail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      dec_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_REQ0;
          dec_q <= decrypt;
        end
        ST_REQ0:  if (req_ready) state <= ST_WAIT0;
        ST_WAIT0: if (rsp_valid) state <= ST_DATA;
        ST_DATA:  if (din_valid) state <= ST_REQ;
        ST_REQ:   if (req_ready) state <= ST_RSP;
        ST_RSP:   if (rsp_valid) state <= last_q ? ST_FIN : ST_DATA;
        ST_FIN:   if (hash_valid) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ek0_q   <= '0;
      data_q  <= '0;
      last_q  <= 1'b0;
      bytes_q <= '0;
    end else begin
      if (state == ST_WAIT0 && rsp_valid) ek0_q <= rsp_block;
      if (take_din) begin
        data_q  <= din_data;
        last_q  <= din_last;
        bytes_q <= din_bytes;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_valid <= 1'b0;
      dout_data  <= '0;
      dout_last  <= 1'b0;
      dout_bytes <= '0;
    end else begin
      dout_valid <= (state == ST_RSP) && rsp_valid;
      if (state == ST_RSP && rsp_valid) begin
        dout_data  <= masked;
        dout_last  <= last_q;
        dout_bytes <= bytes_q;
      end
    end
  end
endmodule

// File: rtl/ctr_tag_unit_chk.sv
module ctr_tag_unit_chk #(
  parameter int BLK_W = 128,
  parameter int IV_W  = 96,
  parameter int CTR_W = 32,
  parameter int TAG_W = 128
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               decrypt,
  input logic [IV_W-1:0]    iv,
  input logic               din_ready,
  input logic               dout_valid,
  input logic               req_valid,
  input logic               req_ready,
  input logic [BLK_W-1:0]   req_block,
  input logic               rsp_valid,
  input logic               tag_valid,
  input logic               auth_pass,
  input logic               auth_fail
);
  localparam int HI_W = BLK_W - CTR_W;

  logic             sess, first_pend, dec_seen, in_flight;
  logic [IV_W-1:0]  iv_seen;
  logic [BLK_W-1:0] prev_blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      sess       <= 1'b0;
      first_pend <= 1'b0;
      dec_seen   <= 1'b0;
      in_flight  <= 1'b0;
      iv_seen    <= '0;
      prev_blk   <= '0;
    end else begin
      if (start && !sess) begin
        sess       <= 1'b1;
        first_pend <= 1'b1;
        dec_seen   <= decrypt;
        iv_seen    <= iv;
      end else if (tag_valid) begin
        sess <= 1'b0;
      end
      if (req_valid && req_ready) begin
        first_pend <= 1'b0;
        prev_blk   <= req_block;
        in_flight  <= 1'b1;
      end else if (rsp_valid) begin
        in_flight <= 1'b0;
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!req_valid && !din_ready && !dout_valid && !tag_valid && !auth_pass && !auth_fail));

  assert_first_counter_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && first_pend) |->
      (req_block == {iv_seen, {(BLK_W-IV_W-1){1'b0}}, 1'b1}));

  assert_counter_step_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !first_pend && sess) |->
      ((req_block[BLK_W-1 -: HI_W] == prev_blk[BLK_W-1 -: HI_W]) &&
       (req_block[CTR_W-1:0] == prev_blk[CTR_W-1:0] + CTR_W'(1))));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_block)));

  assert_verdict_R8: assert property (@(posedge clk) disable iff (rst)
    (auth_pass || auth_fail) |-> (tag_valid && dec_seen && $countones({auth_pass, auth_fail}) == 1));

  assert_idle_no_ready_R9: assert property (@(posedge clk) disable iff (rst)
    !sess |-> !din_ready);

  assert_single_flight_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !in_flight);
endmodule

bind ctr_tag_unit ctr_tag_unit_chk #(
  .BLK_W(BLK_W), .IV_W(IV_W), .CTR_W(CTR_W), .TAG_W(TAG_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .decrypt    (decrypt),
  .iv         (iv),
  .din_ready  (din_ready),
  .dout_valid (dout_valid),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_block  (req_block),
  .rsp_valid  (rsp_valid),
  .tag_valid  (tag_valid),
  .auth_pass  (auth_pass),
  .auth_fail  (auth_fail)
);

// File: tb/test_ctr_tag_unit.sv
module test_ctr_tag_unit;
  localparam int BLK_W = 128;
  localparam int IV_W  = 96;
  localparam int TAG_W = 96;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start = 1'b0, decrypt = 1'b0;
  logic [IV_W-1:0]    iv = '0;
  logic               din_valid = 1'b0, din_ready, din_last = 1'b0;
  logic [BLK_W-1:0]   din_data = '0;
  logic [6:0]         din_bytes = '0;
  logic               dout_valid, dout_last;
  logic [BLK_W-1:0]   dout_data;
  logic [6:0]         dout_bytes;
  logic               req_valid, req_ready = 1'b0;
  logic [BLK_W-1:0]   req_block;
  logic               rsp_valid = 1'b0;
  logic [BLK_W-1:0]   rsp_block = '0;
  logic               hash_valid = 1'b0;
  logic [BLK_W-1:0]   hash_in = '0;
  logic [TAG_W-1:0]   tag_ref = '0;
  logic               tag_valid, auth_pass, auth_fail;
  logic [TAG_W-1:0]   tag_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ctr_tag_unit #(.BLK_W(BLK_W), .IV_W(IV_W), .CTR_W(32), .TAG_W(TAG_W)) i_ctr_tag_unit (
    .clk(clk), .rst(rst), .start(start), .decrypt(decrypt), .iv(iv),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .din_last(din_last), .din_bytes(din_bytes),
    .dout_valid(dout_valid), .dout_data(dout_data), .dout_last(dout_last),
    .dout_bytes(dout_bytes),
    .req_valid(req_valid), .req_ready(req_ready), .req_block(req_block),
    .rsp_valid(rsp_valid), .rsp_block(rsp_block),
    .hash_valid(hash_valid), .hash_in(hash_in), .tag_ref(tag_ref),
    .tag_valid(tag_valid), .tag_out(tag_out),
    .auth_pass(auth_pass), .auth_fail(auth_fail)
  );

  typedef struct packed {
    logic [95:0] iv;
    logic        dec;
    logic [6:0]  bytes;
    logic        match;
    logic [3:0]  nblk;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{96'h0,                          1'b0, 7'd16, 1'b1, 4'd1},
    '{96'hCAFEBABE_01234567_89ABCDEF, 1'b0, 7'd5,  1'b1, 4'd3},
    '{96'hFFFFFFFF_FFFFFFFF_FFFFFFFF, 1'b1, 7'd16, 1'b1, 4'd2},
    '{96'h12345678_9ABCDEF0_0F1E2D3C, 1'b1, 7'd1,  1'b0, 4'd2},
    '{96'hAAAAAAAA_55555555_AAAAAAAA, 1'b0, 7'd0,  1'b1, 4'd2},
    '{96'h55555555_AAAAAAAA_00000001, 1'b1, 7'd15, 1'b1, 4'd1}
  };

  function automatic logic [127:0] ciph(input logic [127:0] x);
    return {x[63:0], x[127:64]} ^ 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
  endfunction

  function automatic logic [127:0] blk_data(input int s, input int i);
    return {32'(s * 7 + i), 32'hDEAD0000 + 32'(i), ~32'(s), 32'h13572468 ^ 32'(i * s + 3)};
  endfunction

  function automatic logic [127:0] keep_mask(input logic last, input logic [6:0] b);
    int nb;
    nb = (!last || b == 7'd0 || b >= 7'd16) ? 16 : int'(b);
    return {128{1'b1}} << ((16 - nb) * 8);
  endfunction

  task automatic check(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic serve_cipher(input int stall, input int lat, output logic [127:0] blk);
    while (!req_valid) @(negedge clk);
    blk = req_block;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check(req_valid && req_block == blk, "R6 request held while stalled", req_block, blk);
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    for (int k = 0; k < lat; k++) @(negedge clk);
    rsp_valid = 1'b1;
    rsp_block = ciph(blk);
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic run_session(input int s);
    vec_t          v;
    logic [127:0]  blk, prev, y0, d, exp, full_tag;
    logic [TAG_W-1:0] exp_tag;
    int            stall, lat;
    v     = VECS[s];
    stall = (s % 2) * 2;
    lat   = 1 + (s % 3);
    @(negedge clk);
    start = 1'b1; decrypt = v.dec; iv = v.iv;
    @(negedge clk);
    start = 1'b0; iv = ~v.iv;
    serve_cipher(stall, lat, blk);
    y0 = {v.iv, 31'b0, 1'b1};
    check(blk == y0, "R2 initial counter", blk, y0);
    prev = blk;
    for (int b = 0; b < int'(v.nblk); b++) begin
      d = blk_data(s, b);
      din_valid = 1'b1; din_data = d;
      din_last  = (b == int'(v.nblk) - 1);
      din_bytes = din_last ? v.bytes : 7'd0;
      while (!din_ready) @(negedge clk);
      @(negedge clk);
      din_valid = 1'b0;
      serve_cipher(stall, lat, blk);
      exp = {prev[127:32], prev[31:0] + 32'd1};
      check(blk == exp, "R3 counter increment", blk, exp);
      prev = blk;
      while (!dout_valid) @(negedge clk);
      exp = (d ^ ciph(blk)) & keep_mask(din_last, din_bytes);
      check(dout_data == exp, din_last && v.bytes != 7'd16 ? "R5 last block mask" : "R4 keystream xor",
            dout_data, exp);
      check(dout_last == din_last && dout_bytes == din_bytes, "R5 last flag and count",
            {dout_last, dout_bytes}, {din_last, din_bytes});
      @(negedge clk);
      check(!dout_valid, "R4 output pulse one cycle", dout_valid, 0);
    end
    full_tag = {v.iv, v.iv[31:0]} ^ ciph(y0) ^ 128'h0;
    exp_tag  = full_tag[127 -: TAG_W];
    hash_valid = 1'b1; hash_in = {v.iv, v.iv[31:0]};
    tag_ref    = v.match ? exp_tag : (exp_tag ^ 96'h1);
    @(negedge clk);
    hash_valid = 1'b0;
    check(tag_valid && tag_out == exp_tag, "R7 tag value", tag_out, exp_tag);
    check(auth_pass == (v.dec && v.match) && auth_fail == (v.dec && !v.match),
          "R8 tag verdict", {auth_pass, auth_fail}, {v.dec && v.match, v.dec && !v.match});
    @(negedge clk);
    check(!tag_valid && !auth_pass && !auth_fail, "R7 tag pulse one cycle",
          {tag_valid, auth_pass, auth_fail}, 0);
  endtask

  initial begin
    for (int k = 0; k < 20000; k++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!req_valid && !din_ready && !dout_valid && !tag_valid && !auth_pass && !auth_fail,
          "R1 reset outputs", {req_valid, din_ready, dout_valid, tag_valid, auth_pass, auth_fail}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!req_valid && !din_ready && !dout_valid && !tag_valid, "R1 after reset",
          {req_valid, din_ready, dout_valid, tag_valid}, 0);

    // R9: data offered with no session running is not taken
    din_valid = 1'b1; din_data = 128'h1234; din_last = 1'b1; din_bytes = 7'd16;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!din_ready && !dout_valid && !req_valid, "R9 idle ignores data",
            {din_ready, dout_valid, req_valid}, 0);
    end
    din_valid = 1'b0;

    for (int s = 0; s < 6; s++) run_session(s);

    // R9: start pulse mid-session is ignored; the counter chain continues
    @(negedge clk);
    start = 1'b1; decrypt = 1'b0; iv = 96'h0000000A_0000000B_0000000C;
    @(negedge clk);
    start = 1'b0;
    begin
      logic [127:0] blk;
      serve_cipher(0, 1, blk);
      din_valid = 1'b1; din_data = 128'h5; din_last = 1'b1; din_bytes = 7'd16;
      while (!din_ready) @(negedge clk);
      @(negedge clk);
      din_valid = 1'b0;
      start = 1'b1; iv = 96'hFFFF;
      @(negedge clk);
      start = 1'b0;
      serve_cipher(0, 1, blk);
      check(blk == {96'h0000000A_0000000B_0000000C, 32'd2}, "R9 start ignored in session",
            blk, {96'h0000000A_0000000B_0000000C, 32'd2});
      while (!dout_valid) @(negedge clk);
      @(negedge clk);
      hash_valid = 1'b1;
      @(negedge clk);
      hash_valid = 1'b0;
      @(negedge clk);
      check(!req_valid && !din_ready, "R9 back to idle", {req_valid, din_ready}, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule